// File: doc/BRIEF.md
# LCD Interrupt Status Controller

This block gathers the event strobes produced by a multi-channel LCD DMA engine and by the panel timing logic, and records them in two sticky status registers. Channel 0 and the global panel events use the first status register. Channels 1 and up use the second. Each status bit has a matching mask bit, and the block combines the unmasked bits into one registered, level-sensitive interrupt line.

When an unmasked frame event or a bus error arrives, the block either captures that channel's frame identifier into an ID register or marks a secondary interrupt. It captures the identifier if the interrupt line is low. It marks the secondary interrupt if the line is already high, so that software can tell the captured identifier belongs to an earlier event. A small control register holds the controller enable and the stop-at-frame-end request, which produce the quick-disable and last-frame indications. Software reads every register through a simple register port and clears status bits by writing ones to them.

Top module: `lcdint_ctrl`

## Requirements
- R1: After reset, both status registers, both mask registers, the ID register and the control register read 0, and `irq_o` is low.
- R2: Status register 0 (address 0) bit positions. Bit 0 is last frame done. Bit 1 is channel 0 start of frame. Bit 2 is bus error. Bit 3 is AC-bias count. Bit 4 is channel 0 input underrun and bit 5 is channel 1 input underrun. Bit 6 is output underrun and bit 7 is quick-disable done. Bit 8 is channel 0 end of frame and bit 9 is channel 0 branch. Bit 10 is the secondary interrupt. Bit 11 is read status and bit 12 is command interrupt.
- R3: Status register 1 (address 1) holds channels ch ≥ 1. Start of frame is at bit ch-1, end of frame at bit ch+7 and branch at bit ch+15. Input underrun for ch ≥ 2 is at bit ch+23.
- R4: A start-of-frame strobe is recorded only while that channel's `sof_int_en_i` bit is 1. An end-of-frame strobe is recorded only while its `eof_int_en_i` bit is 1.
- R5: A bus error on any channel sets status 0 bit 2. It also writes the number of the lowest erroring channel into status 0 bits 30:28. Masks do not affect this.
- R6: `irq_o` is a register. It goes high one clock after any status bit with a clear mask bit is set. Mask 0 (address 2) uses the status 0 bit positions for bits 12:0, and mask 1 (address 3) uses the status 1 positions.
- R7: When `irq_o` is low, an unmasked start-of-frame, end-of-frame or branch event, or any bus error, loads that channel's frame ID into the ID register (address 4). If several channels qualify in the same cycle, the lowest-numbered channel wins.
- R8: When `irq_o` is high, such an event sets status 0 bit 10 and leaves the ID register unchanged.
- R9: Writing status 0 clears each of bits 11:0 written as 1. Bit 12 is never cleared this way. Writing a 1 to bit 2 also clears bits 30:28.
- R10: Writing status 1 clears only the written-1 bits that lie inside 0x003E3F3F. All other status 1 bits stay set until reset.
- R11: If a strobe sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R12: Writing the control register (address 5, bit 0 enable, bit 1 stop at frame end) with bit 0 = 0 while enable is 1 sets status 0 bit 7.
- R13: A `frame_end_i` strobe while both enable and stop are 1 sets status 0 bit 0 and clears enable. It does not set bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_evt_i | input | NUM_CH | Per-channel start-of-frame strobe |
| eof_evt_i | input | NUM_CH | Per-channel end-of-frame strobe |
| branch_evt_i | input | NUM_CH | Per-channel branch strobe |
| underrun_evt_i | input | NUM_CH | Per-channel input underrun strobe |
| bus_err_i | input | NUM_CH | Per-channel bus error strobe |
| sof_int_en_i | input | NUM_CH | Descriptor start-of-frame report enable |
| eof_int_en_i | input | NUM_CH | Descriptor end-of-frame report enable |
| frame_id_i | input | NUM_CH*ID_W | Per-channel frame identifier, channel 0 in the low slice |
| frame_end_i | input | 1 | End of the current display frame |
| ac_bias_evt_i | input | 1 | AC-bias count strobe |
| out_underrun_i | input | 1 | Output underrun strobe |
| read_status_i | input | 1 | Panel read status strobe |
| command_int_i | input | 1 | Command interrupt strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is an event that arrives while the registered interrupt line is already high. At the ports this shows up only as the secondary bit together with an ID register that did not change. To reach it, the bench sets one status bit, waits the extra clock the interrupt register needs, and then sends a second channel's event. The same-cycle race between a write-one-to-clear and a new strobe is created the same way: one task drives the register write and the event in a single cycle, after the interrupt has already risen. The bench also reaches the status 1 bits that software cannot clear. It writes all ones to status 1 and expects those bits to stay set.

// File: rtl/lcdint_pkg.sv
package lcdint_pkg;

    // Status register 0 bit positions
    localparam int S0_LDD   = 0;
    localparam int S0_SOF0  = 1;
    localparam int S0_BER   = 2;
    localparam int S0_ABC   = 3;
    localparam int S0_IU0   = 4;
    localparam int S0_IU1   = 5;
    localparam int S0_OU    = 6;
    localparam int S0_QD    = 7;
    localparam int S0_EOF0  = 8;
    localparam int S0_BS0   = 9;
    localparam int S0_SEC   = 10;
    localparam int S0_RDST  = 11;
    localparam int S0_CMD   = 12;
    localparam int BERCH_LO = 28;
    localparam int BERCH_W  = 3;

    localparam logic [31:0] S0_EVT_BITS  = 32'h0000_1FFF;
    localparam logic [31:0] S0_CLR_BITS  = 32'h0000_0FFF;
    localparam logic [31:0] S0_BERCH_FLD = 32'h7000_0000;
    localparam logic [31:0] S1_CLR_BITS  = 32'h003E_3F3F;
    localparam logic [31:0] S1_MASK_BITS = 32'h3F3F_3F3F;

    // Control register bits
    localparam int CTL_EN  = 0;
    localparam int CTL_DIS = 1;

    typedef enum logic [2:0] {
        RA_STAT0 = 3'd0,
        RA_STAT1 = 3'd1,
        RA_MASK0 = 3'd2,
        RA_MASK1 = 3'd3,
        RA_FID   = 3'd4,
        RA_CTRL  = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/lcdint_event_map.sv
module lcdint_event_map
    import lcdint_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic [NUM_CH-1:0] sof_i,
    input  logic [NUM_CH-1:0] eof_i,
    input  logic [NUM_CH-1:0] brs_i,
    input  logic [NUM_CH-1:0] iu_i,
    input  logic [NUM_CH-1:0] sof_en_i,
    input  logic [NUM_CH-1:0] eof_en_i,
    input  logic [31:0]       mask0_i,
    input  logic [31:0]       mask1_i,
    output logic [31:0]       set0_o,
    output logic [31:0]       set1_o,
    output logic [NUM_CH-1:0] hit_o
);

    logic [NUM_CH-1:0] sof_ok;
    logic [NUM_CH-1:0] eof_ok;
    logic [31:0]       s0_part [NUM_CH];
    logic [31:0]       s1_part [NUM_CH];

    assign sof_ok = sof_i & sof_en_i;
    assign eof_ok = eof_i & eof_en_i;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam bit IN_S0 = (ch == 0);
        localparam bit IU_S0 = (ch < 2);
        localparam int P_SOF = IN_S0 ? S0_SOF0 : ch - 1;
        localparam int P_EOF = IN_S0 ? S0_EOF0 : ch + 7;
        localparam int P_BS  = IN_S0 ? S0_BS0  : ch + 15;
        localparam int P_IU  = (ch == 0) ? S0_IU0 : ((ch == 1) ? S0_IU1 : ch + 23);

        logic [31:0] msk;
        logic [31:0] frame_vec;
        logic [31:0] iu_vec;

        assign msk       = IN_S0 ? mask0_i : mask1_i;
        assign frame_vec = ({31'b0, sof_ok[ch]} << P_SOF)
                         | ({31'b0, eof_ok[ch]} << P_EOF)
                         | ({31'b0, brs_i[ch]}  << P_BS);
        assign iu_vec    = {31'b0, iu_i[ch]} << P_IU;

        assign s0_part[ch] = (IN_S0 ? frame_vec : 32'b0) | (IU_S0 ? iu_vec : 32'b0);
        assign s1_part[ch] = (IN_S0 ? 32'b0 : frame_vec) | (IU_S0 ? 32'b0 : iu_vec);
        assign hit_o[ch]   = |(frame_vec & ~msk);
    end

    always_comb begin
        set0_o = '0;
        set1_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            set0_o = set0_o | s0_part[i];
            set1_o = set1_o | s1_part[i];
        end
    end

endmodule

// File: rtl/lcdint_id_select.sv
module lcdint_id_select
    import lcdint_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ID_W   = 32
) (
    input  logic [NUM_CH-1:0]      hit_i,
    input  logic [NUM_CH-1:0]      berr_i,
    input  logic [NUM_CH*ID_W-1:0] frame_id_i,
    input  logic                   irq_i,
    output logic                   cap_en_o,
    output logic [ID_W-1:0]        cap_id_o,
    output logic                   sec_set_o,
    output logic                   berr_any_o,
    output logic [BERCH_W-1:0]     berr_ch_o
);

    logic [NUM_CH-1:0] want;
    logic              any_want;

    assign want     = hit_i | berr_i;
    assign any_want = |want;

    // Descending scan so the lowest-numbered channel is left selected
    always_comb begin
        cap_id_o  = '0;
        berr_ch_o = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (want[i]) begin
                cap_id_o = frame_id_i[i*ID_W +: ID_W];
            end
            if (berr_i[i]) begin
                berr_ch_o = BERCH_W'(i);
            end
        end
    end

    assign berr_any_o = |berr_i;
    assign cap_en_o   = any_want && !irq_i;
    assign sec_set_o  = any_want && irq_i;

endmodule

// File: rtl/lcdint_ctrl.sv
module lcdint_ctrl
    import lcdint_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ID_W   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      sof_evt_i,
    input  logic [NUM_CH-1:0]      eof_evt_i,
    input  logic [NUM_CH-1:0]      branch_evt_i,
    input  logic [NUM_CH-1:0]      underrun_evt_i,
    input  logic [NUM_CH-1:0]      bus_err_i,
    input  logic [NUM_CH-1:0]      sof_int_en_i,
    input  logic [NUM_CH-1:0]      eof_int_en_i,
    input  logic [NUM_CH*ID_W-1:0] frame_id_i,
    input  logic                   frame_end_i,
    input  logic                   ac_bias_evt_i,
    input  logic                   out_underrun_i,
    input  logic                   read_status_i,
    input  logic                   command_int_i,
    input  logic [2:0]             reg_addr_i,
    input  logic                   reg_wr_i,
    input  logic [31:0]            reg_wdata_i,
    output logic [31:0]            reg_rdata_o,
    output logic                   irq_o
);

    localparam int CH_MAX = 7;

    typedef struct packed {
        logic [31:0]     stat0;
        logic [31:0]     stat1;
        logic [31:0]     mask0;
        logic [31:0]     mask1;
        logic [ID_W-1:0] fid;
        logic            ctrl_en;
        logic            ctrl_dis;
        logic            irq;
    } state_t;

    state_t cur_q;
    state_t nxt_d;

    logic [31:0]        map_set0;
    logic [31:0]        map_set1;
    logic [NUM_CH-1:0]  chan_hit;
    logic               cap_en;
    logic [ID_W-1:0]    cap_id;
    logic               sec_set;
    logic               berr_any;
    logic [BERCH_W-1:0] berr_ch;

    if (NUM_CH > CH_MAX || NUM_CH < 1 || ID_W > 32 || ID_W < 1) begin : g_bad_param
        initial $error("lcdint_ctrl: unsupported NUM_CH or ID_W");
    end

    lcdint_event_map #(.NUM_CH(NUM_CH)) u_event_map (
        .sof_i    (sof_evt_i),
        .eof_i    (eof_evt_i),
        .brs_i    (branch_evt_i),
        .iu_i     (underrun_evt_i),
        .sof_en_i (sof_int_en_i),
        .eof_en_i (eof_int_en_i),
        .mask0_i  (cur_q.mask0),
        .mask1_i  (cur_q.mask1),
        .set0_o   (map_set0),
        .set1_o   (map_set1),
        .hit_o    (chan_hit)
    );

    lcdint_id_select #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_id_select (
        .hit_i      (chan_hit),
        .berr_i     (bus_err_i),
        .frame_id_i (frame_id_i),
        .irq_i      (cur_q.irq),
        .cap_en_o   (cap_en),
        .cap_id_o   (cap_id),
        .sec_set_o  (sec_set),
        .berr_any_o (berr_any),
        .berr_ch_o  (berr_ch)
    );

    // Next-state computation
    always_comb begin
        logic        wr_s0, wr_s1, wr_m0, wr_m1, wr_ctl;
        logic [31:0] clr0, clr1, set0;
        logic        last_frame;

        nxt_d  = cur_q;

        wr_s0  = reg_wr_i && (reg_addr_i == RA_STAT0);
        wr_s1  = reg_wr_i && (reg_addr_i == RA_STAT1);
        wr_m0  = reg_wr_i && (reg_addr_i == RA_MASK0);
        wr_m1  = reg_wr_i && (reg_addr_i == RA_MASK1);
        wr_ctl = reg_wr_i && (reg_addr_i == RA_CTRL);

        clr0 = wr_s0 ? (reg_wdata_i & S0_CLR_BITS) : 32'b0;
        if (wr_s0 && reg_wdata_i[S0_BER]) begin
            clr0 = clr0 | S0_BERCH_FLD;
        end
        clr1 = wr_s1 ? (reg_wdata_i & S1_CLR_BITS) : 32'b0;

        last_frame = frame_end_i && cur_q.ctrl_en && cur_q.ctrl_dis;

        set0           = map_set0;
        set0[S0_LDD]   = set0[S0_LDD]  | last_frame;
        set0[S0_BER]   = set0[S0_BER]  | berr_any;
        set0[S0_ABC]   = set0[S0_ABC]  | ac_bias_evt_i;
        set0[S0_OU]    = set0[S0_OU]   | out_underrun_i;
        set0[S0_QD]    = set0[S0_QD]   | (wr_ctl && cur_q.ctrl_en && !reg_wdata_i[CTL_EN]);
        set0[S0_SEC]   = set0[S0_SEC]  | sec_set;
        set0[S0_RDST]  = set0[S0_RDST] | read_status_i;
        set0[S0_CMD]   = set0[S0_CMD]  | command_int_i;

        // Clear first, then set: a same-cycle strobe wins
        nxt_d.stat0 = (cur_q.stat0 & ~clr0) | set0;
        if (berr_any) begin
            nxt_d.stat0[BERCH_LO +: BERCH_W] = berr_ch;
        end
        nxt_d.stat1 = (cur_q.stat1 & ~clr1) | map_set1;

        if (wr_m0) begin
            nxt_d.mask0 = reg_wdata_i & S0_EVT_BITS;
        end
        if (wr_m1) begin
            nxt_d.mask1 = reg_wdata_i & S1_MASK_BITS;
        end

        if (cap_en) begin
            nxt_d.fid = cap_id;
        end

        if (wr_ctl) begin
            nxt_d.ctrl_en  = reg_wdata_i[CTL_EN];
            nxt_d.ctrl_dis = reg_wdata_i[CTL_DIS];
        end
        if (last_frame) begin
            nxt_d.ctrl_en = 1'b0;
        end

        nxt_d.irq = (|(cur_q.stat0 & S0_EVT_BITS & ~cur_q.mask0))
                  | (|(cur_q.stat1 & ~cur_q.mask1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // Register read port
    always_comb begin
        case (reg_addr_i)
            RA_STAT0: reg_rdata_o = cur_q.stat0;
            RA_STAT1: reg_rdata_o = cur_q.stat1;
            RA_MASK0: reg_rdata_o = cur_q.mask0;
            RA_MASK1: reg_rdata_o = cur_q.mask1;
            RA_FID:   reg_rdata_o = 32'(cur_q.fid);
            RA_CTRL:  reg_rdata_o = {30'b0, cur_q.ctrl_dis, cur_q.ctrl_en};
            default:  reg_rdata_o = 32'b0;
        endcase
    end

    assign irq_o = cur_q.irq;

endmodule

// File: rtl/lcdint_checker.sv
module lcdint_checker #(
    parameter int NUM_CH = 7,
    parameter int ID_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] sof_i,
    input logic [NUM_CH-1:0] sof_en_i,
    input logic [NUM_CH-1:0] hit_i,
    input logic [NUM_CH-1:0] berr_i,
    input logic              frame_end_i,
    input logic [31:0]       stat0_i,
    input logic [31:0]       stat1_i,
    input logic              ctrl_en_i,
    input logic              ctrl_dis_i,
    input logic [ID_W-1:0]   fid_i,
    input logic              irq_i
);

    // R6: nothing pending means the line is low next cycle
    p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0_i[12:0] == '0 && stat1_i == '0) |=> !irq_i);

    // R4: a disabled start-of-frame leaves bit 1 clear
    p_sof_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat0_i[1] && sof_i[0] && !sof_en_i[0]) |=> !stat0_i[1]);

    // R11: an enabled start of frame always lands, even against a clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i[0] && sof_en_i[0]) |=> stat0_i[1]);

    // R5: bus error always recorded
    p_berr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|berr_i) |=> stat0_i[2]);

    // R8: event under a raised line marks secondary and keeps the ID
    p_secondary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && (|(hit_i | berr_i))) |=> (stat0_i[10] && $stable(fid_i)));

    // R13: stop at frame end records last frame and drops enable
    p_last_frame_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && ctrl_en_i && ctrl_dis_i) |=> (stat0_i[0] && !ctrl_en_i));

    // R10: channel 1 branch bit lies outside the clear set
    if (NUM_CH > 1) begin : g_sticky
        p_s1_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            stat1_i[16] |=> stat1_i[16]);
    end

endmodule

bind lcdint_ctrl lcdint_checker #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_lcdint_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof_i       (sof_evt_i),
    .sof_en_i    (sof_int_en_i),
    .hit_i       (chan_hit),
    .berr_i      (bus_err_i),
    .frame_end_i (frame_end_i),
    .stat0_i     (cur_q.stat0),
    .stat1_i     (cur_q.stat1),
    .ctrl_en_i   (cur_q.ctrl_en),
    .ctrl_dis_i  (cur_q.ctrl_dis),
    .fid_i       (cur_q.fid),
    .irq_i       (cur_q.irq)
);

// File: tb/test_lcdint_ctrl.sv
module test_lcdint_ctrl;

    localparam int NUM_CH = 7;
    localparam int ID_W   = 32;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NUM_CH-1:0]      sof_evt = '0, eof_evt = '0, branch_evt = '0;
    logic [NUM_CH-1:0]      underrun_evt = '0, bus_err = '0;
    logic [NUM_CH-1:0]      sof_en = '1, eof_en = '1;
    logic [NUM_CH*ID_W-1:0] frame_id = '0;
    logic                   frame_end = 1'b0, ac_bias = 1'b0, out_ur = 1'b0;
    logic                   rd_status = 1'b0, cmd_int = 1'b0;
    logic [2:0]             reg_addr = '0;
    logic                   reg_wr = 1'b0;
    logic [31:0]            reg_wdata = '0;
    logic [31:0]            reg_rdata;
    logic                   irq;

    always #5 clk = ~clk;

    lcdint_ctrl #(.NUM_CH(NUM_CH), .ID_W(ID_W)) i_lcdint_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .sof_evt_i      (sof_evt),
        .eof_evt_i      (eof_evt),
        .branch_evt_i   (branch_evt),
        .underrun_evt_i (underrun_evt),
        .bus_err_i      (bus_err),
        .sof_int_en_i   (sof_en),
        .eof_int_en_i   (eof_en),
        .frame_id_i     (frame_id),
        .frame_end_i    (frame_end),
        .ac_bias_evt_i  (ac_bias),
        .out_underrun_i (out_ur),
        .read_status_i  (rd_status),
        .command_int_i  (cmd_int),
        .reg_addr_i     (reg_addr),
        .reg_wr_i       (reg_wr),
        .reg_wdata_i    (reg_wdata),
        .reg_rdata_o    (reg_rdata),
        .irq_o          (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    event      chk_ev;
    int        n_chk = 0;
    int        n_fail = 0;
    bit        done = 1'b0;

    function automatic logic [31:0] fid(input int ch);
        return 32'hF1D0_0000 + 32'(ch);
    endfunction

    // Monitor: pops expectations and compares against the live outputs
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (exp_q.size() > 0) begin
                exp_item_t it;
                logic [31:0] act;
                it  = exp_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : reg_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Advance one clock (one rising edge) and drop all strobes
    task automatic step();
        @(negedge clk);
        sof_evt = '0; eof_evt = '0; branch_evt = '0; underrun_evt = '0; bus_err = '0;
        frame_end = 1'b0; ac_bias = 1'b0; out_ur = 1'b0; rd_status = 1'b0; cmd_int = 1'b0;
        reg_wr = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        reg_addr = a; reg_wr = 1'b0;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        ->chk_ev;
        #2;
        step();
    endtask

    task automatic chk_irq(input logic e, input string tag);
        exp_item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        exp_q.push_back(it);
        ->chk_ev;
        #2;
        step();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NUM_CH; c++) frame_id[c*ID_W +: ID_W] = fid(c);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk_reg(0, 32'h0, "R1 stat0");
        chk_reg(1, 32'h0, "R1 stat1");
        chk_reg(2, 32'h0, "R1 mask0");
        chk_reg(4, 32'h0, "R1 fid");
        chk_reg(5, 32'h0, "R1 ctrl");
        chk_irq(1'b0, "R1 irq");

        // Channel 0 start of frame
        sof_evt[0] = 1'b1; step();
        chk_irq(1'b0, "R6 irq lags status");
        chk_reg(0, 32'h0000_0002, "R2 sof0 bit1");
        chk_irq(1'b1, "R6 irq raised");
        chk_reg(4, fid(0), "R7 capture ch0");

        // Event while the line is high
        eof_evt[3] = 1'b1; step();
        chk_reg(0, 32'h0000_0402, "R8 secondary bit");
        chk_reg(1, 32'h0000_0400, "R3 eof ch3 bit10");
        chk_reg(4, fid(0), "R8 id held");

        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFF);
        chk_reg(0, 32'h0, "R9 clear stat0");
        chk_reg(1, 32'h0, "R10 clear stat1");
        chk_irq(1'b0, "R6 irq falls");

        // Report enables off
        sof_en = '0; eof_en = '0;
        sof_evt[0] = 1'b1; sof_evt[2] = 1'b1; eof_evt[0] = 1'b1; eof_evt[5] = 1'b1; step();
        chk_reg(0, 32'h0, "R4 gated stat0");
        chk_reg(1, 32'h0, "R4 gated stat1");
        chk_irq(1'b0, "R4 no irq");
        sof_en = '1; eof_en = '1;

        // Bus error on two channels
        bus_err[5] = 1'b1; bus_err[3] = 1'b1; step();
        chk_reg(0, 32'h3000_0004, "R5 bus error ch3");
        chk_reg(4, fid(3), "R7 capture on bus error");
        wr(0, 32'h0000_0004);
        chk_reg(0, 32'h0, "R9 field cleared");

        // Masked bus error still recorded and captured
        wr(2, 32'h0000_0004);
        bus_err[5] = 1'b1; step();
        chk_reg(0, 32'h5000_0004, "R5 masked bus error");
        chk_reg(4, fid(5), "R7 capture masked bus error");
        chk_irq(1'b0, "R6 mask0 blocks irq");
        wr(0, 32'h0000_0004);
        wr(2, 32'h0);
        chk_reg(0, 32'h0, "R9 clear again");

        // Priority between channels
        sof_evt[4] = 1'b1; sof_evt[2] = 1'b1; step();
        chk_reg(4, fid(2), "R7 lowest channel wins");
        chk_reg(1, 32'h0000_000A, "R3 sof ch2 ch4");
        wr(1, 32'h0000_000A);
        chk_reg(1, 32'h0, "R10 clear sof bits");

        // Masked event: no capture, no irq
        wr(3, 32'hFFFF_FFFF);
        eof_evt[6] = 1'b1; step();
        chk_reg(1, 32'h0000_2000, "R3 eof ch6 bit13");
        chk_reg(4, fid(2), "R7 masked no capture");
        chk_irq(1'b0, "R6 mask1 blocks irq");
        wr(1, 32'h0000_2000);
        wr(3, 32'h0);

        // Set wins against a same-cycle clear
        sof_evt[0] = 1'b1; step();
        chk_reg(0, 32'h0000_0002, "R11 pre set");
        sof_evt[0] = 1'b1; wr(0, 32'h0000_0002);
        chk_reg(0, 32'h0000_0402, "R11 set beats clear");
        wr(0, 32'h0000_0FFF);
        chk_reg(0, 32'h0, "R9 clear bits");

        // Underruns and channel 1 branch
        branch_evt[1] = 1'b1; underrun_evt[0] = 1'b1; underrun_evt[1] = 1'b1;
        underrun_evt[4] = 1'b1; step();
        chk_reg(0, 32'h0000_0030, "R2 underrun bits");
        chk_reg(1, 32'h0801_0000, "R3 branch ch1 iu ch4");
        chk_reg(4, fid(1), "R7 capture branch ch1");
        wr(1, 32'hFFFF_FFFF);
        chk_reg(1, 32'h0801_0000, "R10 bits outside clear set");
        wr(0, 32'h0000_0030);
        wr(3, 32'h0801_0000);
        chk_reg(0, 32'h0, "R9 underruns cleared");
        chk_irq(1'b0, "R6 mask1 hides sticky bits");

        // Channel 0 branch and global strobes
        branch_evt[0] = 1'b1; out_ur = 1'b1; ac_bias = 1'b1; step();
        chk_reg(0, 32'h0000_0248, "R2 branch ou abc");
        chk_reg(4, fid(0), "R7 capture branch ch0");
        wr(0, 32'h0000_0FFF);
        chk_reg(0, 32'h0, "R9 clear globals");

        // Quick disable
        wr(5, 32'h1);
        wr(5, 32'h0);
        chk_reg(0, 32'h0000_0080, "R12 quick disable");
        chk_reg(5, 32'h0, "R12 ctrl off");
        wr(0, 32'h0000_0080);

        // Stop at frame end
        wr(5, 32'h3);
        frame_end = 1'b1; step();
        chk_reg(0, 32'h0000_0001, "R13 last frame done");
        chk_reg(5, 32'h2, "R13 enable dropped");
        wr(0, 32'h0000_0001);

        // Read status and command interrupt
        rd_status = 1'b1; cmd_int = 1'b1; step();
        chk_reg(0, 32'h0000_1800, "R2 rdst cmd bits");
        wr(0, 32'h0000_1FFF);
        chk_reg(0, 32'h0000_1000, "R9 bit12 not clearable");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule